// File: doc/BRIEF.md
# TDM Clock Failure Monitor

This block supervises the timing of a TDM port. A free-running monitor clock samples four timing inputs: the 8 kHz reference fed to an external PLL, and the three bus timing signals (the double-rate bit clock, the single-rate bit clock and the frame sync). It also samples one external clock-fail line. Each timing input has its own silence counter. When a signal shows no edge for a programmable number of monitor cycles, a sticky status bit is set.

The reference-loss status also drives a free-run request to the external PLL. That request stays asserted after the reference comes back and drops only when software clears the status. When the block runs as an alternate bus master, a rising external clock-fail line makes it request takeover of the bus timing. Software clears each status bit with a one-cycle write-one-to-clear strobe and enables interrupts per source and globally.

Top module: `tdm_clk_monitor`

## Requirements
- R1: `refFailSts` becomes 1 once `refClk` has shown no edge for about `REF_TIMEOUT` monitor cycles. It stays 0 while `refClk` toggles with a half period shorter than that timeout.
- R2: `freeRunReq` is 1 whenever `refFailSts` is 1. It stays 1 after `refClk` resumes, and falls only when `clrRefFail` clears the status.
- R3: `clkAbsentSts` becomes 1 when any one of `busClk2x`, `busClk1x` or `frameSync` is silent past its timeout (`BIT_TIMEOUT` for the two bit clocks, `FS_TIMEOUT` for the frame sync). A silent bus signal does not set `refFailSts`.
- R4: `clkFailSts` becomes 1 a few monitor cycles after `extFail` is driven high, whatever the value of `altMasterMode`.
- R5: A one-cycle clear strobe (`clrRefFail`, `clrClkAbsent`, `clrClkFail`) makes its status bit read 0 in the following cycle. If the failure is still present, the bit is set again one cycle later. If the failure has gone, the bit stays 0.
- R6: `takeoverReq` is set when `extFail` rises while `altMasterMode` is 1. It is not set when `altMasterMode` is 0 at the rise, nor when the mode is turned on while `extFail` is already high. It is held until `altMasterMode` returns to 0.
- R7: `irq` equals `irqGlobalEn AND ((refFailSts AND ieRefFail) OR (clkAbsentSts AND ieClkAbsent) OR (clkFailSts AND ieClkFail))`.
- R8: While `rstN` is low, and right after it is released, all status bits, `freeRunReq`, `takeoverReq` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock |
| rstN | input | 1 | Active-low synchronous reset |
| refClk | input | 1 | 8 kHz reference to the external PLL |
| busClk2x | input | 1 | Double-rate TDM bit clock |
| busClk1x | input | 1 | Single-rate TDM bit clock |
| frameSync | input | 1 | TDM frame sync |
| extFail | input | 1 | External clock-fail line |
| altMasterMode | input | 1 | Device is configured as alternate bus master |
| clrRefFail | input | 1 | Write-one-to-clear strobe for reference-loss status |
| clrClkAbsent | input | 1 | Write-one-to-clear strobe for bus-clock-absent status |
| clrClkFail | input | 1 | Write-one-to-clear strobe for external-fail status |
| ieRefFail | input | 1 | Interrupt enable, reference loss |
| ieClkAbsent | input | 1 | Interrupt enable, bus clock absent |
| ieClkFail | input | 1 | Interrupt enable, external fail |
| irqGlobalEn | input | 1 | Global TDM interrupt enable |
| refFailSts | output | 1 | Sticky reference-loss status |
| clkAbsentSts | output | 1 | Sticky bus-clock-absent status |
| clkFailSts | output | 1 | Sticky external-fail status |
| freeRunReq | output | 1 | Free-run request to the external PLL |
| takeoverReq | output | 1 | Request to become bus timing master |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume the clear strobes are single-cycle pulses driven away from the clock edge. They also assume the timing inputs may arrive asynchronous to the monitor clock but change no faster than the monitor clock can follow. The bench drives every input at the falling edge of the monitor clock and toggles each timing signal at a whole number of monitor cycles. A signal is stopped right after one of its edges, so the silent interval is known to the cycle. Silence windows are chosen well inside or well outside each timeout, clear of the synchronizer's few cycles of uncertainty.

// File: rtl/tdm_mon_pkg.sv
package tdm_mon_pkg;
  // Channel indices of the activity monitor
  localparam int NUM_CH = 4;
  localparam int CH_REF = 0;
  localparam int CH_X2  = 1;
  localparam int CH_X1  = 2;
  localparam int CH_FS  = 3;

  // Strobes from the detection datapath to the status control
  typedef struct packed {
    logic refLost;      // reference silent past its timeout
    logic busLost;      // at least one bus timing signal silent
    logic extFailHigh;  // synchronized external fail level
    logic extFailRise;  // one-cycle rising edge of external fail
  } monEvt_t;
endpackage

// File: rtl/tdm_mon_sync.sv
module tdm_mon_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/tdm_mon_datapath.sv
module tdm_mon_datapath
  import tdm_mon_pkg::*;
#(
  parameter int REF_TIMEOUT = 16384,
  parameter int BIT_TIMEOUT = 512,
  parameter int FS_TIMEOUT  = 16384,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] timingIn,
  input  logic              extFailIn,
  output monEvt_t           evt
);
  localparam int MAX_TO = (REF_TIMEOUT > FS_TIMEOUT) ?
                          ((REF_TIMEOUT > BIT_TIMEOUT) ? REF_TIMEOUT : BIT_TIMEOUT) :
                          ((FS_TIMEOUT > BIT_TIMEOUT) ? FS_TIMEOUT : BIT_TIMEOUT);
  localparam int CNT_W = $clog2(MAX_TO + 1);

  function automatic int chanTimeout(input int ch);
    if (ch == CH_REF) return REF_TIMEOUT;
    if (ch == CH_FS)  return FS_TIMEOUT;
    return BIT_TIMEOUT;
  endfunction

  logic [NUM_CH:0] rawIn;
  logic [NUM_CH:0] syncIn;
  logic [NUM_CH:0] prevIn;
  logic [NUM_CH-1:0] chanLost;

  assign rawIn = {extFailIn, timingIn};

  tdm_mon_sync #(.WIDTH(NUM_CH + 1), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  // One silence counter per timing channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    localparam int TO = chanTimeout(ch);
    localparam logic [CNT_W-1:0] TO_V = CNT_W'(TO);
    logic [CNT_W-1:0] quietCnt;
    logic edgeSeen;

    assign edgeSeen = syncIn[ch] ^ prevIn[ch];

    always_ff @(posedge clk) begin
      if (!rstN)                quietCnt <= '0;
      else if (edgeSeen)        quietCnt <= '0;
      else if (quietCnt < TO_V) quietCnt <= quietCnt + 1'b1;
    end

    assign chanLost[ch] = (quietCnt >= TO_V);
  end

  always_comb begin
    evt.refLost     = chanLost[CH_REF];
    evt.busLost     = chanLost[CH_X2] | chanLost[CH_X1] | chanLost[CH_FS];
    evt.extFailHigh = syncIn[NUM_CH];
    evt.extFailRise = syncIn[NUM_CH] & ~prevIn[NUM_CH];
  end
endmodule

// File: rtl/tdm_mon_ctrl.sv
module tdm_mon_ctrl
  import tdm_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  monEvt_t evt,
  input  logic    altMasterMode,
  input  logic    clrRefFail,
  input  logic    clrClkAbsent,
  input  logic    clrClkFail,
  input  logic    ieRefFail,
  input  logic    ieClkAbsent,
  input  logic    ieClkFail,
  input  logic    irqGlobalEn,
  output logic    refFailSts,
  output logic    clkAbsentSts,
  output logic    clkFailSts,
  output logic    freeRunReq,
  output logic    takeoverReq,
  output logic    irq
);
  logic [2:0] stsQ, stsD, setCond, clrVec, ieVec;

  assign setCond = {evt.extFailHigh, evt.busLost, evt.refLost};
  assign clrVec  = {clrClkFail, clrClkAbsent, clrRefFail};
  assign ieVec   = {ieClkFail, ieClkAbsent, ieRefFail};

  // A clear wins for one cycle; a persisting fault sets the bit again after it
  always_comb begin
    for (int b = 0; b < 3; b++)
      stsD[b] = clrVec[b] ? 1'b0 : (stsQ[b] | setCond[b]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ        <= '0;
      takeoverReq <= 1'b0;
    end else begin
      stsQ <= stsD;
      if (!altMasterMode)       takeoverReq <= 1'b0;
      else if (evt.extFailRise) takeoverReq <= 1'b1;
    end
  end

  assign refFailSts   = stsQ[0];
  assign clkAbsentSts = stsQ[1];
  assign clkFailSts   = stsQ[2];
  assign freeRunReq   = stsQ[0];
  assign irq          = irqGlobalEn & |(stsQ & ieVec);
endmodule

// File: rtl/tdm_clk_monitor.sv
module tdm_clk_monitor
  import tdm_mon_pkg::*;
#(
  parameter int REF_TIMEOUT = 16384,
  parameter int BIT_TIMEOUT = 512,
  parameter int FS_TIMEOUT  = 16384,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refClk,
  input  logic busClk2x,
  input  logic busClk1x,
  input  logic frameSync,
  input  logic extFail,
  input  logic altMasterMode,
  input  logic clrRefFail,
  input  logic clrClkAbsent,
  input  logic clrClkFail,
  input  logic ieRefFail,
  input  logic ieClkAbsent,
  input  logic ieClkFail,
  input  logic irqGlobalEn,
  output logic refFailSts,
  output logic clkAbsentSts,
  output logic clkFailSts,
  output logic freeRunReq,
  output logic takeoverReq,
  output logic irq
);
  monEvt_t evt;
  logic [NUM_CH-1:0] timingIn;

  always_comb begin
    timingIn         = '0;
    timingIn[CH_REF] = refClk;
    timingIn[CH_X2]  = busClk2x;
    timingIn[CH_X1]  = busClk1x;
    timingIn[CH_FS]  = frameSync;
  end

  tdm_mon_datapath #(
    .REF_TIMEOUT (REF_TIMEOUT),
    .BIT_TIMEOUT (BIT_TIMEOUT),
    .FS_TIMEOUT  (FS_TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .timingIn  (timingIn),
    .extFailIn (extFail),
    .evt       (evt)
  );

  tdm_mon_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .evt           (evt),
    .altMasterMode (altMasterMode),
    .clrRefFail    (clrRefFail),
    .clrClkAbsent  (clrClkAbsent),
    .clrClkFail    (clrClkFail),
    .ieRefFail     (ieRefFail),
    .ieClkAbsent   (ieClkAbsent),
    .ieClkFail     (ieClkFail),
    .irqGlobalEn   (irqGlobalEn),
    .refFailSts    (refFailSts),
    .clkAbsentSts  (clkAbsentSts),
    .clkFailSts    (clkFailSts),
    .freeRunReq    (freeRunReq),
    .takeoverReq   (takeoverReq),
    .irq           (irq)
  );
endmodule

// File: rtl/tdm_clk_monitor_chk.sv
module tdm_clk_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic altMasterMode,
  input logic clrRefFail,
  input logic clrClkAbsent,
  input logic clrClkFail,
  input logic irqGlobalEn,
  input logic refFailSts,
  input logic clkAbsentSts,
  input logic clkFailSts,
  input logic freeRunReq,
  input logic takeoverReq,
  input logic irq
);
  // R2: the free-run request holds until software clears the reference status
  p_freerun_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (freeRunReq && !clrRefFail) |=> freeRunReq);

  // R5: a sticky bit holds without a clear
  p_sticky_absent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkAbsentSts && !clrClkAbsent) |=> clkAbsentSts);

  // R5: a clear strobe empties the bit in the next cycle
  p_clear_ref_r5: assert property (@(posedge clk) disable iff (!rstN)
    clrRefFail |=> !refFailSts);

  p_clear_fail_r5: assert property (@(posedge clk) disable iff (!rstN)
    clrClkFail |=> !clkFailSts);

  // R6: leaving alternate-master mode withdraws the takeover request
  p_takeover_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    !altMasterMode |=> !takeoverReq);

  // R7: no interrupt without the global enable or without a status source
  p_irq_global_r7: assert property (@(posedge clk) disable iff (!rstN)
    !irqGlobalEn |-> !irq);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (refFailSts || clkAbsentSts || clkFailSts));
endmodule

bind tdm_clk_monitor tdm_clk_monitor_chk uChk (
  .clk           (clk),
  .rstN          (rstN),
  .altMasterMode (altMasterMode),
  .clrRefFail    (clrRefFail),
  .clrClkAbsent  (clrClkAbsent),
  .clrClkFail    (clrClkFail),
  .irqGlobalEn   (irqGlobalEn),
  .refFailSts    (refFailSts),
  .clkAbsentSts  (clkAbsentSts),
  .clkFailSts    (clkFailSts),
  .freeRunReq    (freeRunReq),
  .takeoverReq   (takeoverReq),
  .irq           (irq)
);

// File: tb/tdm_clk_monitor_test.sv
module tdm_clk_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int REF_TO = 40;
  localparam int BIT_TO = 12;
  localparam int FS_TO  = 40;

  // {irqGlobalEn, ieRefFail, ieClkAbsent, ieClkFail, expected irq}, all statuses set
  localparam logic [4:0] IRQ_VEC [8] = '{
    5'b0111_0, 5'b1000_0, 5'b1100_1, 5'b1010_1,
    5'b1001_1, 5'b1111_1, 5'b0000_0, 5'b0100_0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refClk = 1'b0, busClk2x = 1'b0, busClk1x = 1'b0, frameSync = 1'b0;
  logic extFail = 1'b0, altMasterMode = 1'b0;
  logic clrRefFail = 1'b0, clrClkAbsent = 1'b0, clrClkFail = 1'b0;
  logic ieRefFail = 1'b0, ieClkAbsent = 1'b0, ieClkFail = 1'b0, irqGlobalEn = 1'b0;
  logic refFailSts, clkAbsentSts, clkFailSts, freeRunReq, takeoverReq, irq;

  logic runRef = 1'b1, runX2 = 1'b1, runX1 = 1'b1, runFs = 1'b1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tdm_clk_monitor #(
    .REF_TIMEOUT (REF_TO),
    .BIT_TIMEOUT (BIT_TO),
    .FS_TIMEOUT  (FS_TO),
    .SYNC_STAGES (2)
  ) uut (
    .clk (clk), .rstN (rstN),
    .refClk (refClk), .busClk2x (busClk2x), .busClk1x (busClk1x), .frameSync (frameSync),
    .extFail (extFail), .altMasterMode (altMasterMode),
    .clrRefFail (clrRefFail), .clrClkAbsent (clrClkAbsent), .clrClkFail (clrClkFail),
    .ieRefFail (ieRefFail), .ieClkAbsent (ieClkAbsent), .ieClkFail (ieClkFail),
    .irqGlobalEn (irqGlobalEn),
    .refFailSts (refFailSts), .clkAbsentSts (clkAbsentSts), .clkFailSts (clkFailSts),
    .freeRunReq (freeRunReq), .takeoverReq (takeoverReq), .irq (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Timing signal generators, all driven at the falling edge
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (runRef) begin c++; if (c >= 15) begin c = 0; refClk = ~refClk; end end
    end
  end
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (runX2) begin c++; if (c >= 2) begin c = 0; busClk2x = ~busClk2x; end end
    end
  end
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (runX1) begin c++; if (c >= 4) begin c = 0; busClk1x = ~busClk1x; end end
    end
  end
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (runFs) begin c = (c >= 29) ? 0 : c + 1; frameSync = (c < 2); end
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    waitCyc(5);
    // R8: reset state
    chk("R8", "refFailSts in reset", refFailSts, 1'b0);
    chk("R8", "takeoverReq in reset", takeoverReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8", "refFailSts after reset", refFailSts, 1'b0);
    chk("R8", "clkAbsentSts after reset", clkAbsentSts, 1'b0);
    chk("R8", "clkFailSts after reset", clkFailSts, 1'b0);
    chk("R8", "freeRunReq after reset", freeRunReq, 1'b0);
    chk("R8", "irq after reset", irq, 1'b0);

    waitCyc(100);
    chk("R1", "no ref fail while toggling", refFailSts, 1'b0);
    chk("R3", "no absence while toggling", clkAbsentSts, 1'b0);

    // R1/R2: stop the reference just after one of its edges
    @(refClk); runRef = 1'b0;
    waitCyc(REF_TO - 2);
    chk("R1", "ref fail before timeout", refFailSts, 1'b0);
    waitCyc(12);
    chk("R1", "ref fail after timeout", refFailSts, 1'b1);
    chk("R2", "freerun with ref fail", freeRunReq, 1'b1);
    chk("R3", "bus status unaffected by ref loss", clkAbsentSts, 1'b0);
    runRef = 1'b1;
    waitCyc(60);
    chk("R2", "freerun held after ref returns", freeRunReq, 1'b1);
    chk("R5", "status sticky after ref returns", refFailSts, 1'b1);
    pulse(clrRefFail);
    waitCyc(3);
    chk("R2", "freerun released by clear", freeRunReq, 1'b0);
    chk("R5", "status clear after clear", refFailSts, 1'b0);

    // R5: clear while the fault persists
    runRef = 1'b0;
    waitCyc(REF_TO + 12);
    chk("R1", "ref fail again", refFailSts, 1'b1);
    clrRefFail = 1'b1;
    @(negedge clk);
    clrRefFail = 1'b0;
    chk("R5", "cleared for one cycle", refFailSts, 1'b0);
    @(negedge clk);
    chk("R5", "re-set while fault persists", refFailSts, 1'b1);
    runRef = 1'b1;
    waitCyc(20);
    pulse(clrRefFail);
    waitCyc(3);
    chk("R5", "stays clear after fault gone", refFailSts, 1'b0);

    // R3: each bus signal on its own
    runX2 = 1'b0;
    waitCyc(BIT_TO + 10);
    chk("R3", "absence on double-rate clock", clkAbsentSts, 1'b1);
    chk("R3", "ref status unaffected by bus loss", refFailSts, 1'b0);
    runX2 = 1'b1; waitCyc(10); pulse(clrClkAbsent); waitCyc(3);
    chk("R5", "absence cleared", clkAbsentSts, 1'b0);

    @(negedge clk); runX1 = 1'b0;
    waitCyc(BIT_TO - 6);
    chk("R3", "no absence before bit timeout", clkAbsentSts, 1'b0);
    waitCyc(16);
    chk("R3", "absence on single-rate clock", clkAbsentSts, 1'b1);
    runX1 = 1'b1; waitCyc(10); pulse(clrClkAbsent); waitCyc(3);
    chk("R5", "absence cleared after single-rate", clkAbsentSts, 1'b0);

    runFs = 1'b0;
    waitCyc(FS_TO + 12);
    chk("R3", "absence on frame sync", clkAbsentSts, 1'b1);
    runFs = 1'b1; waitCyc(40); pulse(clrClkAbsent); waitCyc(3);
    chk("R5", "absence cleared after frame sync", clkAbsentSts, 1'b0);

    // R4/R6: external fail with mode off, then mode on while already high
    extFail = 1'b1;
    waitCyc(6);
    chk("R4", "clock fail status with mode off", clkFailSts, 1'b1);
    chk("R6", "no takeover with mode off", takeoverReq, 1'b0);
    altMasterMode = 1'b1;
    waitCyc(6);
    chk("R6", "no takeover on mode set with fail already high", takeoverReq, 1'b0);
    extFail = 1'b0;
    waitCyc(6);
    pulse(clrClkFail);
    waitCyc(3);
    chk("R5", "clock fail cleared", clkFailSts, 1'b0);
    extFail = 1'b1;
    waitCyc(6);
    chk("R6", "takeover on rise in alternate mode", takeoverReq, 1'b1);
    chk("R4", "clock fail status in alternate mode", clkFailSts, 1'b1);
    extFail = 1'b0;
    waitCyc(10);
    chk("R6", "takeover held after fail drops", takeoverReq, 1'b1);
    altMasterMode = 1'b0;
    waitCyc(2);
    chk("R6", "takeover withdrawn with mode", takeoverReq, 1'b0);

    // R7: interrupt gating with all three statuses set
    runRef = 1'b0; runX2 = 1'b0; extFail = 1'b1;
    waitCyc(REF_TO + 12);
    chk("R7", "all statuses set", refFailSts & clkAbsentSts & clkFailSts, 1'b1);
    for (int i = 0; i < 8; i++) begin
      {irqGlobalEn, ieRefFail, ieClkAbsent, ieClkFail} = IRQ_VEC[i][4:1];
      @(negedge clk);
      chk("R7", $sformatf("irq vector %0d", i), irq, IRQ_VEC[i][0]);
    end

    // R7: a single source with its enable off raises nothing
    runRef = 1'b1; runX2 = 1'b1; extFail = 1'b0;
    waitCyc(20);
    pulse(clrRefFail); pulse(clrClkAbsent); pulse(clrClkFail);
    extFail = 1'b1;
    {irqGlobalEn, ieRefFail, ieClkAbsent, ieClkFail} = 4'b1110;
    waitCyc(6);
    chk("R7", "fail source masked", irq, 1'b0);
    ieClkFail = 1'b1;
    @(negedge clk);
    chk("R7", "fail source enabled", irq, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule